// File: doc/BRIEF.md
# Speculative Equal-Weight Counter with Error Correction

This block adds up between two and five single-bit inputs that all carry the same weight. It gives a one-bit sum and a one-bit carry whose value 2·carry+sum is correct whenever at most three inputs are set. The carry is built from small at-least-two cells whose results are joined by OR. When four or more ones arrive this cell structure cannot represent the count, and the carry saturates. The block is meant to go inside a fast reduction tree, where its short carry path lies on the critical path.

A correction unit sits beside the counter and sees the same inputs. It raises an error flag exactly when the fast result is short, and it gives a one-bit correction word of weight two. Adding twice that word to 2·carry+sum gives the true count of ones, so a slower recovery path can rebuild the exact sum. The number of inputs is a parameter that picks one of four carry structures. Values outside two to five are rejected when the design is elaborated. The block has no clock and no state.

Top module: `spec_counter`

## Requirements
- R1: `sum_o` equals the XOR of all `NUM_IN` inputs for every input combination.
- R2: `carry_o` is high exactly when at least two inputs are high, for every supported `NUM_IN`.
- R3: Whenever three or fewer inputs are high, 2·`carry_o`+`sum_o` equals the number of high inputs. This includes the all-zero input, where every output is low.
- R4: `err_o` is high exactly when four or more inputs are high. It is low for every combination where 2·`carry_o`+`sum_o` is already exact.
- R5: `corr_o` is one bit of weight two. For every input combination, 2·`carry_o`+`sum_o`+2·`corr_o` equals the number of high inputs.
- R6: With `NUM_IN` of 2 or 3, `err_o` and `corr_o` stay low for every input combination.
- R7: With `NUM_IN` = 4, `corr_o` is high only when all four inputs are 1.
- R8: With `NUM_IN` = 5 and all inputs high, `sum_o`, `carry_o`, `err_o` and `corr_o` are all 1, so the restored total is 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_bits | input | NUM_IN | Equal-weight input bits; bit 0 is x0 |
| sum_o | output | 1 | Speculative sum bit, weight 1 |
| carry_o | output | 1 | Speculative carry bit, weight 2 |
| err_o | output | 1 | High when the speculative result is short |
| corr_o | output | 1 | Correction word, weight 2 |

## Verification
The bench builds four copies of the counter, with `NUM_IN` set to 2, 3, 4 and 5. Together these reach every carry structure: the plain AND, the majority, the triple-plus-single split and the triple-plus-pair split. All four copies are driven from one shared five-bit stimulus that sweeps all 32 values, so each width sees every one of its input combinations. The five-input copy also walks a table of hand-picked vectors. Some of these place the two ones inside one subset and some place them across subsets. The table also holds the four-one and five-one overflow cases.

// File: rtl/spec_cnt_pkg.sv
package spec_cnt_pkg;
   localparam int MIN_IN = 2;
   localparam int MAX_IN = 5;
   // first input count from which the speculative carry can be short
   localparam int SHORT_FROM = 4;

   function automatic int pop_width(input int n);
      int w;
      w = 1;
      while ((1 << w) <= n) w++;
      return w;
   endfunction
endpackage

// File: rtl/scnt_triple_cell.sv
// Modified full adder: OR of three bits and their at-least-two function.
module scnt_triple_cell (
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   output logic any_o,
   output logic two_o
);
   assign any_o = a_i | b_i | c_i;
   assign two_o = (a_i & b_i) | (b_i & c_i) | (a_i & c_i);

   always_comb begin
      if (!$isunknown({a_i, b_i, c_i})) begin
         AST_TRIPLE_TWO_IMPLIES_ANY: assert (!two_o || any_o); // R2
      end
   end
endmodule

// File: rtl/scnt_pair_cell.sv
// Modified half adder: OR of two bits and their at-least-two function.
module scnt_pair_cell (
   input  logic a_i,
   input  logic b_i,
   output logic any_o,
   output logic two_o
);
   assign any_o = a_i | b_i;
   assign two_o = a_i & b_i;

   always_comb begin
      if (!$isunknown({a_i, b_i})) begin
         AST_PAIR_TWO_IMPLIES_ANY: assert (!two_o || any_o); // R2
      end
   end
endmodule

// File: rtl/scnt_carry_tree.sv
// At-least-two carry, one structure per input count.
module scnt_carry_tree #(
   parameter int NUM_IN = 5
) (
   input  logic [NUM_IN-1:0] x_i,
   output logic              carry_o
);
   generate
      if (NUM_IN == 2) begin : g_two
         assign carry_o = x_i[0] & x_i[1];
      end else if (NUM_IN == 3) begin : g_three
         assign carry_o = (x_i[0] & x_i[1]) | (x_i[1] & x_i[2]) | (x_i[0] & x_i[2]);
      end else if (NUM_IN == 4) begin : g_four
         logic lo_any, lo_two;
         scnt_triple_cell u_lo (
            .a_i  (x_i[0]),
            .b_i  (x_i[1]),
            .c_i  (x_i[2]),
            .any_o(lo_any),
            .two_o(lo_two)
         );
         assign carry_o = lo_two | (lo_any & x_i[3]);
      end else begin : g_five
         logic lo_any, lo_two, hi_any, hi_two;
         scnt_triple_cell u_lo (
            .a_i  (x_i[0]),
            .b_i  (x_i[1]),
            .c_i  (x_i[2]),
            .any_o(lo_any),
            .two_o(lo_two)
         );
         scnt_pair_cell u_hi (
            .a_i  (x_i[3]),
            .b_i  (x_i[4]),
            .any_o(hi_any),
            .two_o(hi_two)
         );
         // final at-least-two stage over the two subset results
         assign carry_o = lo_two | hi_two | (lo_any & hi_any);
      end
   endgenerate

   always_comb begin
      if (!$isunknown(x_i)) begin
         AST_CARRY_AT_LEAST_TWO: assert (carry_o == ($countones(x_i) >= 2)); // R2
      end
   end
endmodule

// File: rtl/scnt_fix_unit.sv
// Correction side block: exact count, error flag and weight-two fix.
module scnt_fix_unit
   import spec_cnt_pkg::*;
#(
   parameter int NUM_IN = 5
) (
   input  logic [NUM_IN-1:0] x_i,
   input  logic              spec_sum_i,
   input  logic              spec_carry_i,
   output logic              err_o,
   output logic              corr_o
);
   localparam int POP_W = pop_width(NUM_IN);

   logic [POP_W-1:0] exact_cnt;
   logic [POP_W:0]   gap;

   always_comb begin
      exact_cnt = '0;
      for (int i = 0; i < NUM_IN; i++) begin
         exact_cnt = exact_cnt + POP_W'(x_i[i]);
      end
   end

   // the missing amount is always even, so its bit 1 is the fix word
   assign gap    = {1'b0, exact_cnt} - (POP_W + 1)'({spec_carry_i, spec_sum_i});
   assign corr_o = gap[1];

   generate
      if (NUM_IN < SHORT_FROM) begin : g_never_short
         assign err_o = 1'b0;
      end else if (NUM_IN == SHORT_FROM) begin : g_all_set
         assign err_o = &x_i;
      end else begin : g_leave_one_out
         logic [NUM_IN-1:0] drop_and;
         for (genvar d = 0; d < NUM_IN; d++) begin : g_drop
            logic [NUM_IN-1:0] mask;
            assign mask        = ~(NUM_IN'(1) << d);
            assign drop_and[d] = &(x_i | ~mask);
         end
         assign err_o = |drop_and;
      end
   endgenerate

   always_comb begin
      if (!$isunknown({x_i, spec_sum_i, spec_carry_i})) begin
         AST_FIX_MATCHES_FLAG: assert (corr_o == err_o); // R4
         AST_GAP_EVEN: assert (gap[0] == 1'b0); // R5
      end
   end
endmodule

// File: rtl/spec_counter.sv
module spec_counter
   import spec_cnt_pkg::*;
#(
   parameter int NUM_IN = 5
) (
   input  logic [NUM_IN-1:0] in_bits,
   output logic              sum_o,
   output logic              carry_o,
   output logic              err_o,
   output logic              corr_o
);
   generate
      if (NUM_IN < MIN_IN || NUM_IN > MAX_IN) begin : g_bad_width
         $error("spec_counter: NUM_IN must lie in 2..5");
      end
   endgenerate

   assign sum_o = ^in_bits;

   scnt_carry_tree #(.NUM_IN(NUM_IN)) u_carry (
      .x_i    (in_bits),
      .carry_o(carry_o)
   );

   scnt_fix_unit #(.NUM_IN(NUM_IN)) u_fix (
      .x_i         (in_bits),
      .spec_sum_i  (sum_o),
      .spec_carry_i(carry_o),
      .err_o       (err_o),
      .corr_o      (corr_o)
   );

   always_comb begin
      if (!$isunknown(in_bits)) begin
         AST_SUM_IS_PARITY_OF_COUNT: assert (sum_o == $countones(in_bits) % 2); // R1
         AST_EXACT_UP_TO_THREE: assert ($countones(in_bits) > 3 ||
            (2 * int'(carry_o) + int'(sum_o)) == $countones(in_bits)); // R3
         AST_FLAG_ONLY_WHEN_SHORT: assert (err_o ==
            ((2 * int'(carry_o) + int'(sum_o)) != $countones(in_bits))); // R4
         AST_RESTORED_TOTAL: assert ((2 * int'(carry_o) + int'(sum_o) + 2 * int'(corr_o))
            == $countones(in_bits)); // R5
      end
   end
endmodule

// File: tb/tb_spec_counter.sv
module tb_spec_counter;
   localparam int WATCHDOG = 20000;
   // table entry: {in[4:0], err, corr, carry, sum} for NUM_IN = 5
   localparam int NVEC = 11;
   localparam logic [8:0] VECS [NVEC] = '{
      {5'b00000, 4'b0000},
      {5'b00001, 4'b0001},
      {5'b10000, 4'b0001},
      {5'b00011, 4'b0010},
      {5'b11000, 4'b0010},
      {5'b10100, 4'b0010},
      {5'b00111, 4'b0011},
      {5'b11001, 4'b0011},
      {5'b01111, 4'b1110},
      {5'b11110, 4'b1110},
      {5'b11111, 4'b1111}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [4:0] stim = '0;
   int checks = 0;
   int fails = 0;
   int cyc = 0;
   logic done = 1'b0;

   logic s5, c5, e5, k5, s4, c4, e4, k4, s3, c3, e3, k3, s2, c2, e2, k2;

   always #4 clk = ~clk;

   spec_counter #(.NUM_IN(5)) dut (
      .in_bits(stim), .sum_o(s5), .carry_o(c5), .err_o(e5), .corr_o(k5));
   spec_counter #(.NUM_IN(4)) dut_w4 (
      .in_bits(stim[3:0]), .sum_o(s4), .carry_o(c4), .err_o(e4), .corr_o(k4));
   spec_counter #(.NUM_IN(3)) dut_w3 (
      .in_bits(stim[2:0]), .sum_o(s3), .carry_o(c3), .err_o(e3), .corr_o(k3));
   spec_counter #(.NUM_IN(2)) dut_w2 (
      .in_bits(stim[1:0]), .sum_o(s2), .carry_o(c2), .err_o(e2), .corr_o(k2));

   task automatic report;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s stim=%b actual=%0d expected=%0d", req, what, stim, act, exp);
      end
   endtask

   task automatic check_width(input int m, input logic s, input logic c,
                              input logic e, input logic k);
      int pop;
      int spec;
      pop = 0;
      for (int i = 0; i < m; i++) pop += int'(stim[i]);
      spec = 2 * int'(c) + int'(s);
      chk("R1", $sformatf("w%0d sum", m), int'(s), pop % 2);
      chk("R2", $sformatf("w%0d carry", m), int'(c), int'(pop >= 2));
      if (pop <= 3) chk("R3", $sformatf("w%0d exact", m), spec, pop);
      chk("R4", $sformatf("w%0d err", m), int'(e), int'(pop >= 4));
      chk("R5", $sformatf("w%0d restored", m), spec + 2 * int'(k), pop);
      if (m < 4) begin
         chk("R6", $sformatf("w%0d err low", m), int'(e), 0);
         chk("R6", $sformatf("w%0d corr low", m), int'(k), 0);
      end
      if (m == 4) chk("R7", "w4 corr all-ones", int'(k), int'(stim[3:0] == 4'hf));
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG && !done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
         report();
      end
   end

   initial begin
      // reset phase: zero inputs, all outputs low (R3)
      stim = '0;
      repeat (3) @(negedge clk);
      #2;
      chk("R3", "reset-phase outputs", int'({e5, k5, c5, s5}), 0);
      rst = 1'b0;

      // table walk, NUM_IN = 5
      for (int n = 0; n < NVEC; n++) begin
         @(negedge clk);
         stim = VECS[n][8:4];
         #2;
         chk("R1", "table sum", int'(s5), int'(VECS[n][0]));
         chk("R2", "table carry", int'(c5), int'(VECS[n][1]));
         chk("R5", "table corr", int'(k5), int'(VECS[n][2]));
         chk("R4", "table err", int'(e5), int'(VECS[n][3]));
      end

      // exhaustive sweep, all widths in parallel
      for (int v = 0; v < 32; v++) begin
         @(negedge clk);
         stim = 5'(v);
         #2;
         check_width(5, s5, c5, e5, k5);
         check_width(4, s4, c4, e4, k4);
         check_width(3, s3, c3, e3, k3);
         check_width(2, s2, c2, e2, k2);
      end

      // corner: five ones on the widest variant (R8)
      @(negedge clk);
      stim = 5'b11111;
      #2;
      chk("R8", "all-ones flags", int'({e5, k5, c5, s5}), 15);
      chk("R8", "all-ones restored", 2 * int'(c5) + int'(s5) + 2 * int'(k5), 5);

      // corner: four-input all ones, corr set (R7); three ones, corr clear
      @(negedge clk);
      stim = 5'b01111;
      #2;
      chk("R7", "w4 full corr", int'(k4), 1);
      @(negedge clk);
      stim = 5'b00111;
      #2;
      chk("R7", "w4 three ones corr", int'(k4), 0);
      chk("R6", "w3 full err", int'(e3), 0);

      done = 1'b1;
      report();
   end
endmodule